// File: doc/BRIEF.md
# Two-Pass 5x5 Wavelet Decomposition Core

This core turns one 5x5 neighbourhood of unsigned pixels into four signed coefficients of a separable, two-level wavelet-style split. The first pass runs one 5-tap kernel down each of the five columns. Each kernel yields a smoothed value and a detail value. The second pass runs the same kernel across the row of five column-smooth values and across the row of five column-detail values. The four results are a smooth term, a horizontal detail, a vertical detail and a diagonal detail.

The kernel takes samples `c0..c4` and works as follows:
- It forms two second differences, `2*c1 - c0 - c2` and `2*c3 - c2 - c4`, and adds them.
- It takes the magnitude of that sum, shifts the magnitude right, and gives the result back the sign of the sum. This rounds toward zero.
- It adds this correction to the centre sample to form the smooth output.
- Its detail output is the first of the two second differences.

The caller builds the windows, normally stepping the window origin by two pixels in each direction, and presents one window per cycle with a valid flag. Results appear two cycles later. Image traversal and memory traffic belong to the surrounding logic.

Top module: `wvlt_quad_core`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is 0 and all four results read 0.
- R2: A window accepted with `in_valid` high in cycle k produces `out_valid` high in cycle k+2, and `out_valid` is low in cycle k+2 when `in_valid` was low in cycle k. A new window may be accepted every cycle.
- R3: Column c of the first pass takes its samples from rows 0 to 4 of that column, in that order. Its detail is `2*row1 - row0 - row2` as a signed value of PIX_W+2 bits. The vertical detail output is the smooth value of the second-pass kernel applied to the five column details.
- R4: The correction term equals sign(s) * (|s| >> ADJ_SHIFT), where s is the sum of the two second differences. This truncates toward zero, so s = -18 with the default shift gives -2. The smooth value is the centre sample plus the correction. The smooth output is the second-pass smooth over the five column-smooth values.
- R5: The horizontal detail output is the second-pass detail over the five column-smooth values, taken with columns 0 to 4 as samples c0 to c4.
- R6: With SAT_OUT=1 (the default), each of the four outputs is the exact result clamped to the signed range [-2^(PIX_W+2), 2^(PIX_W+2)-1]. The diagonal detail output is the second-pass detail over the five column details. With SAT_OUT=0, the low PIX_W+3 bits are kept.
- R7: In any cycle where `out_valid` is low, all four results keep the values they held in the previous cycle.
- R8: The pixel at row r and column c occupies bits `[(r*5+c)*PIX_W +: PIX_W]` of `in_win`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Window on `in_win` is to be processed this cycle |
| in_win | input | 25*PIX_W | 5x5 window of unsigned pixels, row-major |
| out_valid | output | 1 | The four results belong to a new window |
| res_smooth | output | PIX_W+3 | Smooth coefficient, signed |
| res_hdet | output | PIX_W+3 | Horizontal detail, signed |
| res_vdet | output | PIX_W+3 | Vertical detail, signed |
| res_ddet | output | PIX_W+3 | Diagonal detail, signed |

## Verification
Two things can happen in the same cycle. A new window can enter the column stage while the previous window's column results move into the output registers, so both register stages load at the same edge. The bench provokes this with long runs of back-to-back valid windows, broken by random idle gaps. Every output cycle is compared against a two-deep queue of values computed from the requirements. In an idle cycle, the bench checks that the previous results are still held rather than overwritten. Directed windows are mixed into these bursts: a negative, non-multiple-of-8 correction, a clamp on the diagonal detail, and a single lit pixel for the layout check.

// File: rtl/wvlt_pkg.sv
package wvlt_pkg;
   // kernel length and window size
   localparam int WV_TAPS = 5;
   localparam int WV_WIN  = WV_TAPS * WV_TAPS;
   // headroom bits inside the kernel so second differences and their sum never wrap
   localparam int WV_GROW = 4;

   function automatic int wv_col_w(input int pix_w);
      return pix_w + 2;
   endfunction

   function automatic int wv_out_w(input int pix_w);
      return pix_w + 3;
   endfunction
endpackage

// File: rtl/wvlt_fit.sv
module wvlt_fit #(
   parameter int IN_W  = 12,
   parameter int OUT_W = 10,
   parameter bit SAT   = 1'b1
) (
   input  logic signed [IN_W-1:0]  din,
   output logic signed [OUT_W-1:0] dout
);
   generate
      if (IN_W <= OUT_W) begin : g_wide
         assign dout = OUT_W'(din);
      end else if (SAT) begin : g_sat
         localparam int HI_I = (1 << (OUT_W - 1)) - 1;
         localparam logic signed [IN_W-1:0] HI = IN_W'(HI_I);
         localparam logic signed [IN_W-1:0] LO = IN_W'(-HI_I - 1);
         always_comb begin
            if (din > HI)      dout = HI[OUT_W-1:0];
            else if (din < LO) dout = LO[OUT_W-1:0];
            else               dout = din[OUT_W-1:0];
         end
      end else begin : g_wrap
         assign dout = din[OUT_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/wvlt_tap5.sv
module wvlt_tap5 import wvlt_pkg::*; #(
   parameter int IN_W      = 8,
   parameter bit IN_SIGNED = 1'b0,
   parameter int OUT_W     = 10,
   parameter int ADJ_SHIFT = 3,
   parameter bit SAT       = 1'b1
) (
   input  logic [WV_TAPS*IN_W-1:0] taps,
   output logic signed [OUT_W-1:0] smooth,
   output logic signed [OUT_W-1:0] detail
);
   localparam int EW = IN_W + WV_GROW;

   logic signed [EW-1:0] x [WV_TAPS];

   for (genvar i = 0; i < WV_TAPS; i++) begin : g_ext
      logic sb;
      assign sb   = IN_SIGNED ? taps[i*IN_W + IN_W - 1] : 1'b0;
      assign x[i] = {{(EW - IN_W){sb}}, taps[i*IN_W +: IN_W]};
   end

   logic signed [EW-1:0] d_lo, d_hi, d_sum, mag, shr, adj, sm_w;
   logic neg;

   always_comb begin
      d_lo  = (x[1] <<< 1) - x[0] - x[2];
      d_hi  = (x[3] <<< 1) - x[2] - x[4];
      d_sum = d_lo + d_hi;
      neg   = d_sum[EW-1];
      // sign-magnitude shift: rounds toward zero for both signs
      mag   = neg ? -d_sum : d_sum;
      shr   = mag >> ADJ_SHIFT;
      adj   = neg ? -shr : shr;
      sm_w  = x[2] + adj;
   end

   wvlt_fit #(.IN_W(EW), .OUT_W(OUT_W), .SAT(SAT)) u_fit_s (.din(sm_w), .dout(smooth));
   wvlt_fit #(.IN_W(EW), .OUT_W(OUT_W), .SAT(SAT)) u_fit_d (.din(d_lo), .dout(detail));
endmodule

// File: rtl/wvlt_col_pass.sv
module wvlt_col_pass import wvlt_pkg::*; #(
   parameter int PIX_W     = 8,
   parameter int CW        = 10,
   parameter int ADJ_SHIFT = 3
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      in_valid,
   input  logic [WV_WIN*PIX_W-1:0]   in_win,
   output logic                      out_valid,
   output logic [WV_TAPS*CW-1:0]     col_sm,
   output logic [WV_TAPS*CW-1:0]     col_dt
);
   logic [WV_WIN*PIX_W-1:0] colm;
   logic [WV_TAPS*CW-1:0]   sm_c, dt_c;

   for (genvar c = 0; c < WV_TAPS; c++) begin : g_col
      for (genvar r = 0; r < WV_TAPS; r++) begin : g_row
         assign colm[(c*WV_TAPS + r)*PIX_W +: PIX_W] = in_win[(r*WV_TAPS + c)*PIX_W +: PIX_W];
      end
      wvlt_tap5 #(
         .IN_W(PIX_W), .IN_SIGNED(1'b0), .OUT_W(CW),
         .ADJ_SHIFT(ADJ_SHIFT), .SAT(1'b1)
      ) u_k (
         .taps  (colm[c*WV_TAPS*PIX_W +: WV_TAPS*PIX_W]),
         .smooth(sm_c[c*CW +: CW]),
         .detail(dt_c[c*CW +: CW])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         col_sm    <= '0;
         col_dt    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            col_sm <= sm_c;
            col_dt <= dt_c;
         end
      end
   end
endmodule

// File: rtl/wvlt_row_pass.sv
module wvlt_row_pass import wvlt_pkg::*; #(
   parameter int CW        = 10,
   parameter int OW        = 11,
   parameter int ADJ_SHIFT = 3,
   parameter bit SAT       = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_valid,
   input  logic [WV_TAPS*CW-1:0]  col_sm,
   input  logic [WV_TAPS*CW-1:0]  col_dt,
   output logic                   out_valid,
   output logic signed [OW-1:0]   o_s,
   output logic signed [OW-1:0]   o_h,
   output logic signed [OW-1:0]   o_v,
   output logic signed [OW-1:0]   o_d
);
   logic signed [OW-1:0] s_c, h_c, v_c, d_c;

   wvlt_tap5 #(
      .IN_W(CW), .IN_SIGNED(1'b1), .OUT_W(OW), .ADJ_SHIFT(ADJ_SHIFT), .SAT(SAT)
   ) u_smooth_row (.taps(col_sm), .smooth(s_c), .detail(h_c));

   wvlt_tap5 #(
      .IN_W(CW), .IN_SIGNED(1'b1), .OUT_W(OW), .ADJ_SHIFT(ADJ_SHIFT), .SAT(SAT)
   ) u_detail_row (.taps(col_dt), .smooth(v_c), .detail(d_c));

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         o_s <= '0;
         o_h <= '0;
         o_v <= '0;
         o_d <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            o_s <= s_c;
            o_h <= h_c;
            o_v <= v_c;
            o_d <= d_c;
         end
      end
   end
endmodule

// File: rtl/wvlt_quad_core.sv
module wvlt_quad_core import wvlt_pkg::*; #(
   parameter int PIX_W     = 8,
   parameter int ADJ_SHIFT = 3,
   parameter bit SAT_OUT   = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       in_valid,
   input  logic [25*PIX_W-1:0]        in_win,
   output logic                       out_valid,
   output logic signed [PIX_W+2:0]    res_smooth,
   output logic signed [PIX_W+2:0]    res_hdet,
   output logic signed [PIX_W+2:0]    res_vdet,
   output logic signed [PIX_W+2:0]    res_ddet
);
   localparam int CW = wv_col_w(PIX_W);
   localparam int OW = wv_out_w(PIX_W);

   generate
      if (PIX_W < 2 || PIX_W > 16) begin : g_bad_pix
         $error("wvlt_quad_core: PIX_W must lie in 2..16");
      end
      if (ADJ_SHIFT < 1 || ADJ_SHIFT > PIX_W) begin : g_bad_shift
         $error("wvlt_quad_core: ADJ_SHIFT must lie in 1..PIX_W");
      end
      if (OW != PIX_W + 3 || WV_WIN != 25) begin : g_bad_geom
         $error("wvlt_quad_core: port widths disagree with package geometry");
      end
   endgenerate

   logic                  s1_v;
   logic [WV_TAPS*CW-1:0] s1_sm, s1_dt;

   wvlt_col_pass #(.PIX_W(PIX_W), .CW(CW), .ADJ_SHIFT(ADJ_SHIFT)) u_cols (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_win(in_win),
      .out_valid(s1_v), .col_sm(s1_sm), .col_dt(s1_dt)
   );

   wvlt_row_pass #(.CW(CW), .OW(OW), .ADJ_SHIFT(ADJ_SHIFT), .SAT(SAT_OUT)) u_rows (
      .clk(clk), .rst(rst), .in_valid(s1_v), .col_sm(s1_sm), .col_dt(s1_dt),
      .out_valid(out_valid), .o_s(res_smooth), .o_h(res_hdet),
      .o_v(res_vdet), .o_d(res_ddet)
   );
endmodule

// File: rtl/wvlt_quad_chk.sv
module wvlt_quad_chk #(
   parameter int PIX_W = 8
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    in_valid,
   input logic                    out_valid,
   input logic signed [PIX_W+2:0] res_smooth,
   input logic signed [PIX_W+2:0] res_hdet,
   input logic signed [PIX_W+2:0] res_vdet,
   input logic signed [PIX_W+2:0] res_ddet,
   input logic                    s1_valid,
   input logic [5*(PIX_W+2)-1:0]  s1_det
);
   localparam int CW  = PIX_W + 2;
   localparam int LIM = 2 * ((1 << PIX_W) - 1);

   // R1: first cycle out of reset shows an idle, cleared output
   a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!out_valid && res_smooth == '0 && res_hdet == '0 &&
                      res_vdet == '0 && res_ddet == '0));

   // R2: two-cycle latency for accepted windows
   a_r2_latency: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ##2 out_valid);

   // R2: no result without a window two cycles earlier
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
      !in_valid |-> ##2 !out_valid);

   // R7: idle cycles keep the previous results
   a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> ($stable(res_smooth) && $stable(res_hdet) &&
                      $stable(res_vdet) && $stable(res_ddet)));

   // R3: column details never exceed the second-difference range of unsigned pixels
   for (genvar c = 0; c < 5; c++) begin : g_rng
      a_r3_col_detail_range: assert property (@(posedge clk) disable iff (rst)
         s1_valid |-> ($signed(s1_det[c*CW +: CW]) >= -LIM &&
                       $signed(s1_det[c*CW +: CW]) <= LIM));
   end
endmodule

bind wvlt_quad_core wvlt_quad_chk #(.PIX_W(PIX_W)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
   .res_smooth(res_smooth), .res_hdet(res_hdet), .res_vdet(res_vdet),
   .res_ddet(res_ddet), .s1_valid(s1_v), .s1_det(s1_dt)
);

// File: tb/sim_wvlt_quad_core.sv
module sim_wvlt_quad_core;
   localparam int PW  = 8;
   localparam int SH  = 3;
   localparam bit SAT = 1'b1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [25*PW-1:0] in_win = '0;
   logic out_valid;
   logic signed [PW+2:0] res_smooth, res_hdet, res_vdet, res_ddet;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int exp_v [2];
   int exp_r [2][4];
   string exp_t [2];
   int held [4];

   always #10 clk = ~clk;

   wvlt_quad_core #(.PIX_W(PW), .ADJ_SHIFT(SH), .SAT_OUT(SAT)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_win(in_win),
      .out_valid(out_valid), .res_smooth(res_smooth), .res_hdet(res_hdet),
      .res_vdet(res_vdet), .res_ddet(res_ddet)
   );

   function automatic int fit(input int v, input int w);
      int hi, lo, m;
      hi = (1 << (w - 1)) - 1;
      lo = -hi - 1;
      if (SAT) begin
         if (v > hi) return hi;
         if (v < lo) return lo;
         return v;
      end
      m = v & ((1 << w) - 1);
      return (m > hi) ? m - (1 << w) : m;
   endfunction

   task automatic kern(input int c [5], input int w, output int sm, output int dt);
      int d0, d1, s, m, adj;
      d0 = 2 * c[1] - c[0] - c[2];
      d1 = 2 * c[3] - c[2] - c[4];
      s = d0 + d1;
      m = (s < 0 ? -s : s) >> SH;
      adj = (s < 0) ? -m : m;
      sm = fit(c[2] + adj, w);
      dt = fit(d0, w);
   endtask

   task automatic model(input int px [5][5], output int r [4]);
      int col [5];
      int sy [5];
      int dy [5];
      for (int c = 0; c < 5; c++) begin
         for (int k = 0; k < 5; k++) col[k] = px[k][c];
         kern(col, PW + 2, sy[c], dy[c]);
      end
      kern(sy, PW + 3, r[0], r[1]);
      kern(dy, PW + 3, r[2], r[3]);
   endtask

   task automatic check(input string tag, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: %s got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   task automatic step(input bit v, input int px [5][5], input string tag);
      int r [4];
      string tg [4];
      @(negedge clk);
      check("R2", "out_valid", int'(out_valid), exp_v[1]);
      if (exp_v[1] != 0) begin
         tg[0] = (exp_t[1] == "") ? "R4" : exp_t[1];
         tg[1] = (exp_t[1] == "") ? "R5" : exp_t[1];
         tg[2] = (exp_t[1] == "") ? "R3" : exp_t[1];
         tg[3] = (exp_t[1] == "") ? "R6" : exp_t[1];
         check(tg[0], "smooth", int'(res_smooth), exp_r[1][0]);
         check(tg[1], "hdet",   int'(res_hdet),   exp_r[1][1]);
         check(tg[2], "vdet",   int'(res_vdet),   exp_r[1][2]);
         check(tg[3], "ddet",   int'(res_ddet),   exp_r[1][3]);
         for (int i = 0; i < 4; i++) held[i] = exp_r[1][i];
      end else begin
         check("R7", "held smooth", int'(res_smooth), held[0]);
         check("R7", "held hdet",   int'(res_hdet),   held[1]);
         check("R7", "held vdet",   int'(res_vdet),   held[2]);
         check("R7", "held ddet",   int'(res_ddet),   held[3]);
      end
      exp_v[1] = exp_v[0];
      exp_r[1] = exp_r[0];
      exp_t[1] = exp_t[0];
      in_valid = v;
      for (int rr = 0; rr < 5; rr++)
         for (int cc = 0; cc < 5; cc++)
            in_win[(rr*5 + cc)*PW +: PW] = PW'(px[rr][cc]);
      if (v) begin
         model(px, r);
         exp_r[0] = r;
      end
      exp_v[0] = v;
      exp_t[0] = tag;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int px [5][5];
      int mode;
      void'($urandom(32'h1d5e_0a17));
      for (int i = 0; i < 2; i++) begin
         exp_v[i] = 0;
         exp_t[i] = "";
         for (int k = 0; k < 4; k++) exp_r[i][k] = 0;
      end
      for (int k = 0; k < 4; k++) held[k] = 0;

      repeat (4) @(negedge clk);
      // R1: outputs idle and cleared under reset
      check("R1", "out_valid in reset", int'(out_valid), 0);
      check("R1", "smooth in reset", int'(res_smooth), 0);
      check("R1", "ddet in reset", int'(res_ddet), 0);
      rst = 1'b0;

      // flat zero window
      for (int r = 0; r < 5; r++) for (int c = 0; c < 5; c++) px[r][c] = 0;
      step(1'b1, px, "");
      // flat full-scale window
      for (int r = 0; r < 5; r++) for (int c = 0; c < 5; c++) px[r][c] = 255;
      step(1'b1, px, "");
      // R4: negative correction with magnitude 18 (not multiple of 8) in column 1
      for (int r = 0; r < 5; r++) for (int c = 0; c < 5; c++) px[r][c] = 0;
      px[2][1] = 9;
      step(1'b1, px, "R4");
      // R6: alternating columns drive the diagonal detail into the clamp
      for (int r = 0; r < 5; r++)
         for (int c = 0; c < 5; c++)
            px[r][c] = (r > 2) ? 0 : ((((r + c) % 2) == 0) ? 255 : 0);
      step(1'b1, px, "R6");
      // R8: single lit pixel at row 1, column 3
      for (int r = 0; r < 5; r++) for (int c = 0; c < 5; c++) px[r][c] = 0;
      px[1][3] = 200;
      step(1'b1, px, "R8");
      step(1'b0, px, "");
      step(1'b0, px, "");

      // random bursts with idle gaps
      for (int n = 0; n < 3000; n++) begin
         mode = $urandom % 4;
         for (int r = 0; r < 5; r++)
            for (int c = 0; c < 5; c++) begin
               case (mode)
                  1:       px[r][c] = ($urandom % 2) ? 255 : 0;
                  2:       px[r][c] = $urandom % 16;
                  default: px[r][c] = $urandom % 256;
               endcase
            end
         step(($urandom % 4) != 0, px, "");
      end
      for (int n = 0; n < 4; n++) step(1'b0, px, "");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule